// File: doc/BRIEF.md
# Bit-Serial Interrupt Contention Arbiter

This block picks the single source that must answer an interrupt acknowledge cycle. One source is the system integration unit, which gathers two interrupt requesters of its own: a periodic timer and the external interrupt pins. Each of the other sources is a peripheral with its own request level. Every source carries a 4-bit contention weight. When the acknowledge strobe is taken, every source whose request level equals the acknowledged level joins contention.

The contenders resolve one weight bit per clock, most significant bit first, over a shared wired-OR line. A contender that offers 0 while the line reads 1 drops out. Contention always runs its full length, even when there is one contender or none. A single clean winner is reported one-hot. A winning weight of zero raises a spurious flag. An empty field raises a no-contender flag, which the bus uses to end the cycle with a bus error. A tie at a non-zero top weight raises a duplicate-weight error instead of naming two winners.

Top module: `irq_contend`

## Requirements
- R1: A peripheral contends when its request level equals `ack_lvl` and `ack_lvl` is non-zero. The integration unit contends when `pit_lvl` or `irq_lvl` equals a non-zero `ack_lvl`. A timer level of 0 never matches, so it never contends.
- R2: The contender with the greatest weight wins. `win` bit 0 stands for the integration unit and bit i+1 for peripheral i.
- R3: `ack_stb` is sampled at a clock edge while the block is idle. The results and a one-cycle `done` pulse appear after the fourth edge that follows that sampling edge.
- R4: If the top surviving weight is 0 and at least one source contended, `spurious` is set with `done` and `win` is all zero.
- R5: If no source contends, `no_contender` is set with `done` and `win` is all zero.
- R6: If two or more contenders share the top non-zero weight, `dup_err` is set with `done` and `win` is all zero.
- R7: When the integration unit wins, `win_timer` is 1 if the timer level matched (the timer outranks the pins) and 0 if only the pins matched.
- R8: Contention always takes the full latency, including with a single contender.
- R9: An `ack_stb`, or a change of levels or weights, during contention has no effect on the running result.
- R10: After reset all outputs are 0 and the block is idle.
- R11: The outputs hold their values until the next `done`. A strobe sampled in the `done` cycle starts a new contention at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ack_stb | input | 1 | Acknowledge strobe |
| ack_lvl | input | 3 | Acknowledged interrupt level |
| pit_lvl | input | 3 | Periodic timer request level (0 = off) |
| irq_lvl | input | 3 | External pin request level |
| sim_fld | input | 4 | Integration unit contention weight |
| mod_lvl | input | N_MOD*3 | Peripheral request levels, peripheral i at bits [3i+2:3i] |
| mod_fld | input | N_MOD*4 | Peripheral weights, peripheral i at bits [4i+3:4i] |
| win | output | N_MOD+1 | One-hot winner |
| win_timer | output | 1 | Integration unit won on behalf of its timer |
| spurious | output | 1 | Winning weight was zero |
| no_contender | output | 1 | Nobody contended (bus error) |
| dup_err | output | 1 | Tie at top non-zero weight |
| done | output | 1 | One-cycle result pulse |

## Verification
Two events can fall in the same cycle: the `done` pulse that ends one contention and the strobe that begins the next. The bench raises the new strobe in the `done` cycle of every run, so each result is followed directly by a fresh contention. It then checks that the next result carries the new inputs and appears after the stated latency. It also drives a stray strobe and new weights in the middle of a contention, and checks that the result still matches the inputs captured at the start.

// File: rtl/irq_contend.sv
module irq_contend #(
  parameter int N_MOD = 4,
  parameter int LVL_W = 3,
  parameter int FLD_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ack_stb,
  input  logic [LVL_W-1:0]         ack_lvl,
  input  logic [LVL_W-1:0]         pit_lvl,
  input  logic [LVL_W-1:0]         irq_lvl,
  input  logic [FLD_W-1:0]         sim_fld,
  input  logic [N_MOD*LVL_W-1:0]   mod_lvl,
  input  logic [N_MOD*FLD_W-1:0]   mod_fld,
  output logic [N_MOD:0]           win,
  output logic                     win_timer,
  output logic                     spurious,
  output logic                     no_contender,
  output logic                     dup_err,
  output logic                     done
);
  localparam int NS = N_MOD + 1;
  localparam int CW = (FLD_W > 1) ? $clog2(FLD_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(FLD_W - 1);

  logic [NS-1:0]             req;
  logic [NS-1:0][FLD_W-1:0]  fld_in;
  logic [NS-1:0][FLD_W-1:0]  fld_q;
  logic [NS-1:0]             alive, alive_nx, bitv, nz;
  logic [CW-1:0]             cnt, pos;
  logic                      busy, tmr_q, line, last;
  logic                      lvl_on, none_left, zero_top, multi;

  assign lvl_on = (ack_lvl != '0);
  assign req[0] = lvl_on && ((pit_lvl == ack_lvl) || (irq_lvl == ack_lvl));
  assign fld_in[0] = sim_fld;

  genvar i;
  generate
    for (i = 0; i < N_MOD; i++) begin : g_src
      assign req[i+1]    = lvl_on && (mod_lvl[i*LVL_W +: LVL_W] == ack_lvl);
      assign fld_in[i+1] = mod_fld[i*FLD_W +: FLD_W];
    end
    for (i = 0; i < NS; i++) begin : g_bit
      assign bitv[i] = fld_q[i][pos];
      assign nz[i]   = |fld_q[i];
    end
  endgenerate

  assign pos       = LAST - cnt;
  assign line      = |(alive & bitv);
  assign alive_nx  = line ? (alive & bitv) : alive;
  assign last      = (cnt == LAST);
  assign none_left = (alive_nx == '0);
  assign zero_top  = ~|(alive_nx & nz);
  assign multi     = ((alive_nx & (alive_nx - 1'b1)) != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; alive <= '0; fld_q <= '0; tmr_q <= 1'b0;
      win <= '0; win_timer <= 1'b0; spurious <= 1'b0;
      no_contender <= 1'b0; dup_err <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (ack_stb) begin
          busy  <= 1'b1;
          cnt   <= '0;
          alive <= req;
          fld_q <= fld_in;
          tmr_q <= lvl_on && (pit_lvl == ack_lvl);
        end
      end else begin
        alive <= alive_nx;
        cnt   <= cnt + 1'b1;
        if (last) begin
          busy         <= 1'b0;
          done         <= 1'b1;
          no_contender <= none_left;
          spurious     <= !none_left && zero_top;
          dup_err      <= !none_left && !zero_top && multi;
          win          <= (none_left || zero_top || multi) ? '0 : alive_nx;
          win_timer    <= !none_left && !zero_top && !multi && alive_nx[0] && tmr_q;
        end
      end
    end
  end

  a_r2_win_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win));
  a_r4_outcome_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones({|win, spurious, no_contender, dup_err}) == 1));
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));
  a_r7_timer_needs_sim: assert property (@(posedge clk) disable iff (!rst_n)
    win_timer |-> win[0]);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(win) && $stable(spurious) && $stable(dup_err)));
  a_r9_busy_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> busy);
endmodule

// File: tb/irq_contend_tb_top.sv
module irq_contend_tb_top;
  localparam int N = 4;
  logic clk = 1'b0, rst_n = 1'b0, ack_stb = 1'b0;
  logic [2:0] ack_lvl = '0, pit_lvl = '0, irq_lvl = '0;
  logic [3:0] sim_fld = '0;
  logic [N*3-1:0] mod_lvl = '0;
  logic [N*4-1:0] mod_fld = '0;
  logic [N:0] win;
  logic win_timer, spurious, no_contender, dup_err, done;

  logic [N:0] e_win;
  logic e_tmr, e_sp, e_nc, e_dup;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  irq_contend #(.N_MOD(N), .LVL_W(3), .FLD_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .ack_stb(ack_stb), .ack_lvl(ack_lvl),
    .pit_lvl(pit_lvl), .irq_lvl(irq_lvl), .sim_fld(sim_fld),
    .mod_lvl(mod_lvl), .mod_fld(mod_fld), .win(win), .win_timer(win_timer),
    .spurious(spurious), .no_contender(no_contender), .dup_err(dup_err), .done(done));

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic calc_exp;
    int mx = -1, cnt = 0, idx = 0;
    for (int s = 0; s <= N; s++) begin
      logic rq; int f;
      if (s == 0) begin
        rq = (ack_lvl != 0) && (pit_lvl == ack_lvl || irq_lvl == ack_lvl);
        f = int'(sim_fld);
      end else begin
        rq = (ack_lvl != 0) && (mod_lvl[(s-1)*3 +: 3] == ack_lvl);
        f = int'(mod_fld[(s-1)*4 +: 4]);
      end
      if (rq) begin
        if (f > mx) begin mx = f; cnt = 1; idx = s; end
        else if (f == mx) cnt++;
      end
    end
    e_win = '0; e_tmr = 0; e_sp = 0; e_nc = 0; e_dup = 0;
    if (mx < 0) e_nc = 1;
    else if (mx == 0) e_sp = 1;
    else if (cnt > 1) e_dup = 1;
    else begin
      e_win[idx] = 1'b1;
      e_tmr = (idx == 0) && (pit_lvl == ack_lvl);
    end
  endtask

  // Called at a negedge; returns at the negedge after the done edge (R3, R8, R11).
  task automatic run_ack(input logic [2:0] lvl, input logic poke);
    ack_lvl = lvl;
    ack_stb = 1'b1;
    calc_exp();
    @(posedge clk);
    @(negedge clk);
    ack_stb = 1'b0;
    if (poke) begin
      ack_stb = 1'b1;
      ack_lvl = lvl + 3'd1;
      mod_fld = ~mod_fld;
      sim_fld = ~sim_fld;
      pit_lvl = pit_lvl + 3'd2;
    end
    @(posedge clk);
    @(negedge clk);
    ack_stb = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(done === 1'b0, "R3 early done", 32'(done), 0);
    @(posedge clk);
    @(negedge clk);
    chk(done === 1'b0, "R8 done before latency", 32'(done), 0);
    @(posedge clk);
    @(negedge clk);
    chk(done === 1'b1, "R3 done pulse", 32'(done), 1);
    chk(win === e_win, poke ? "R9 win after busy strobe" : "R2 win", 32'(win), 32'(e_win));
    chk(win_timer === e_tmr, "R7 win_timer", 32'(win_timer), 32'(e_tmr));
    chk(spurious === e_sp, "R4 spurious", 32'(spurious), 32'(e_sp));
    chk(no_contender === e_nc, "R5 no_contender", 32'(no_contender), 32'(e_nc));
    chk(dup_err === e_dup, "R6 dup_err", 32'(dup_err), 32'(e_dup));
  endtask

  task automatic clear_src;
    mod_lvl = '0; mod_fld = '0; pit_lvl = '0; irq_lvl = '0; sim_fld = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(win === '0 && done === 0 && spurious === 0 && no_contender === 0 && dup_err === 0 && win_timer === 0,
        "R10 reset state", 32'({win, done, spurious, no_contender, dup_err}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    clear_src(); mod_lvl[2*3 +: 3] = 3'd5; mod_fld[2*4 +: 4] = 4'd9;
    run_ack(3'd5, 0);                                    // R8 single contender, R1
    chk(win[3] === 1'b1, "R1 single module wins", 32'(win), 32'h8);
    clear_src(); pit_lvl = 3'd4; irq_lvl = 3'd2; sim_fld = 4'd15; mod_lvl[0 +: 3] = 3'd4; mod_fld[0 +: 4] = 4'd14;
    run_ack(3'd4, 0);                                    // R7 timer
    clear_src(); irq_lvl = 3'd3; sim_fld = 4'd6; mod_lvl[3 +: 3] = 3'd3; mod_fld[4 +: 4] = 4'd5;
    run_ack(3'd3, 0);                                    // R7 pins only
    clear_src(); mod_lvl[0 +: 3] = 3'd1; mod_fld[0 +: 4] = 4'd7; mod_lvl[9 +: 3] = 3'd1; mod_fld[12 +: 4] = 4'd7;
    run_ack(3'd1, 0);                                    // R6 tie
    clear_src(); mod_lvl[3 +: 3] = 3'd6; mod_fld[4 +: 4] = 4'd0;
    run_ack(3'd6, 0);                                    // R4 zero weight
    clear_src(); mod_lvl[3 +: 3] = 3'd6; mod_fld[4 +: 4] = 4'd8;
    run_ack(3'd2, 0);                                    // R5 level mismatch
    clear_src(); irq_lvl = 3'd5; sim_fld = 4'd3;
    run_ack(3'd0, 0);                                    // R1 level 0 never contends, R5
    clear_src(); mod_lvl = {3'd2, 3'd2, 3'd2, 3'd2}; mod_fld = {4'd12, 4'd13, 4'd4, 4'd1};
    run_ack(3'd2, 1);                                    // R9 strobe during contention
    ack_lvl = 3'd7; mod_lvl = '1; mod_fld = '1;
    repeat (3) @(negedge clk);
    chk(win === e_win && done === 0, "R11 hold after done", 32'(win), 32'(e_win));

    for (int n = 0; n < 300; n++) begin
      for (int m = 0; m < N; m++) begin
        mod_lvl[m*3 +: 3] = 3'($urandom_range(0, 7));
        mod_fld[m*4 +: 4] = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 2)) : 4'($urandom_range(0, 15));
      end
      pit_lvl = 3'($urandom_range(0, 7));
      irq_lvl = 3'($urandom_range(0, 7));
      sim_fld = 4'($urandom_range(0, 15));
      run_ack(($urandom_range(0, 1) == 0) ? mod_lvl[2:0] : 3'($urandom_range(0, 7)), n % 17 == 0);
    end
    summary();
  end
endmodule